// File: doc/BRIEF.md
# Effective Address Generator with Auto-Modify

This block turns the addressing-mode prefix byte at the front of an instruction into everything the operand stage needs before it touches memory: which addressing mode applies, whether the operand is a byte or a word, how many bytes the prefix group occupies, which base register it names, and the 16-bit operand address. The caller supplies the prefix byte, the one or two bytes that follow it, the current value of the base register that the prefix selects, and whether the coming access is a read or a write.

Two modes change their base register as a side effect. Pre-decrement lowers the register by the operand size and then uses the lowered value as the address. Post-increment uses the register as it stands and raises it by the operand size afterwards, but only when the access is a read. For these modes the block presents the new register value together with a write-back enable. All address arithmetic wraps within 16 bits. A prefix that names no mode raises an illegal flag and never requests a write-back. All outputs are registered, one clock after the inputs.

Top module: `ea_addr_gen`

## Requirements
- R1: While the synchronous reset is high, every output is driven to zero on the next clock edge.
- R2: Each output reflects the inputs sampled at the previous rising clock edge, exactly one cycle of latency.
- R3: A prefix with high nibble A through F selects, in that nibble order, the modes register direct, pre-decrement, post-increment, register indirect, 8-bit displacement and 16-bit displacement (mode codes 0, 1, 2, 3, 4, 5 on `mode_o`); prefix bit 3 gives word size (`word_o`) and bits 2:0 give `reg_o`.
- R4: The prefix length `len_o` is 1 for high nibbles A to D, 2 for E, 3 for F, 2 for the byte immediate, 3 for the word immediate and 3 for both absolute prefixes.
- R5: Prefix 0x04 gives byte immediate (code 6), 0x0C gives word immediate (code 7), 0x15 gives absolute byte and 0x1D gives absolute word (both code 8); for these `reg_o` is 0.
- R6: In pre-decrement mode the address and `wb_val_o` both equal the base minus the operand size (1 or 2) modulo 2^16, and `wb_en_o` is 1 for reads and writes.
- R7: In post-increment mode the address equals the base; on a read `wb_en_o` is 1 and `wb_val_o` is the base plus the operand size modulo 2^16; on a write `wb_en_o` is 0.
- R8: Register indirect gives the base as address; the 8-bit displacement mode adds the sign-extended first extension byte to the base; the 16-bit displacement mode adds {first, second} extension byte as a signed value; all modulo 2^16.
- R9: The absolute modes give the address {first, second} extension byte; `addr_valid_o` is 1 for modes 1, 2, 3, 4, 5 and 8, and for all other modes it is 0 with `addr_o` 0.
- R10: Any other prefix sets `illegal_o`, drives mode code 15, and gives zero length, size, register, address and write-back.
- R11: Whenever `wb_en_o` is 0, `wb_val_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prefix_i | input | 8 | Addressing-mode prefix byte |
| ext_hi_i | input | 8 | First byte following the prefix |
| ext_lo_i | input | 8 | Second byte following the prefix |
| base_i | input | 16 | Value of the base register named by the prefix |
| is_write_i | input | 1 | 1 when the operand access is a write |
| mode_o | output | 4 | Decoded mode code |
| word_o | output | 1 | 1 for a word operand, 0 for a byte |
| len_o | output | 2 | Prefix group length in bytes |
| reg_o | output | 3 | Base register index |
| illegal_o | output | 1 | Prefix names no mode |
| addr_valid_o | output | 1 | The mode produces a memory address |
| addr_o | output | 16 | Operand address |
| wb_en_o | output | 1 | Base register must be updated |
| wb_val_o | output | 16 | New base register value |

## Verification
The hardest situations to reach are the auto-modify wrap points: pre-decrement from base 0x0000 and 0x0001, and post-increment from 0xFFFF and 0xFFFE, each with the read/write indication in both states so that the suppressed write-back on post-increment writes is seen. The stimulus drives these bases directly for every auto-modify prefix, sweeps all 256 prefix values in both access directions, and then adds random prefixes, bases and extension bytes, so that negative displacements and carries out of bit 15 occur in every displacement mode.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    localparam int ADDR_W   = 16;
    localparam int PREFIX_W = 8;
    localparam int REG_W    = 3;
    localparam int LEN_W    = 2;

    // special prefix values
    localparam logic [PREFIX_W-1:0] PFX_IMM_B = 8'h04;
    localparam logic [PREFIX_W-1:0] PFX_IMM_W = 8'h0C;
    localparam logic [PREFIX_W-1:0] PFX_ABS_B = 8'h15;
    localparam logic [PREFIX_W-1:0] PFX_ABS_W = 8'h1D;

    typedef enum logic [3:0] {
        MODE_REG     = 4'd0,
        MODE_PREDEC  = 4'd1,
        MODE_POSTINC = 4'd2,
        MODE_IND     = 4'd3,
        MODE_DISP8   = 4'd4,
        MODE_DISP16  = 4'd5,
        MODE_IMM8    = 4'd6,
        MODE_IMM16   = 4'd7,
        MODE_ABS     = 4'd8,
        MODE_BAD     = 4'd15
    } ea_mode_e;

    typedef struct packed {
        ea_mode_e          mode;
        logic              word;
        logic [LEN_W-1:0]  len;
        logic [REG_W-1:0]  reg_idx;
        logic              illegal;
        logic              has_addr;
    } ea_dec_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wb_en;
        logic [ADDR_W-1:0] wb_val;
    } ea_calc_t;

    // operand size in bytes as an address-width step
    function automatic logic [ADDR_W-1:0] size_step(input logic word);
        return word ? ADDR_W'(2) : ADDR_W'(1);
    endfunction

    // register-family mode chosen by the high nibble (A..F)
    function automatic ea_mode_e family_mode(input logic [3:0] nib);
        case (nib)
            4'hA:    return MODE_REG;
            4'hB:    return MODE_PREDEC;
            4'hC:    return MODE_POSTINC;
            4'hD:    return MODE_IND;
            4'hE:    return MODE_DISP8;
            4'hF:    return MODE_DISP16;
            default: return MODE_BAD;
        endcase
    endfunction

endpackage

// File: rtl/ea_prefix_decode.sv
module ea_prefix_decode
    import ea_gen_pkg::*;
(
    input  logic [PREFIX_W-1:0] prefix_i,
    output ea_dec_t             dec_o
);

    logic [3:0] nib;
    assign nib = prefix_i[PREFIX_W-1 -: 4];

    always_comb begin
        dec_o          = '0;
        dec_o.mode     = MODE_BAD;
        dec_o.illegal  = 1'b1;
        if (nib >= 4'hA) begin
            dec_o.mode     = family_mode(nib);
            dec_o.word     = prefix_i[3];
            dec_o.reg_idx  = prefix_i[REG_W-1:0];
            dec_o.illegal  = 1'b0;
            dec_o.has_addr = (nib != 4'hA);
            case (nib)
                4'hE:    dec_o.len = LEN_W'(2);
                4'hF:    dec_o.len = LEN_W'(3);
                default: dec_o.len = LEN_W'(1);
            endcase
        end else begin
            case (prefix_i)
                PFX_IMM_B: begin
                    dec_o.mode    = MODE_IMM8;
                    dec_o.len     = LEN_W'(2);
                    dec_o.illegal = 1'b0;
                end
                PFX_IMM_W: begin
                    dec_o.mode    = MODE_IMM16;
                    dec_o.word    = 1'b1;
                    dec_o.len     = LEN_W'(3);
                    dec_o.illegal = 1'b0;
                end
                PFX_ABS_B, PFX_ABS_W: begin
                    dec_o.mode     = MODE_ABS;
                    dec_o.word     = (prefix_i == PFX_ABS_W);
                    dec_o.len      = LEN_W'(3);
                    dec_o.illegal  = 1'b0;
                    dec_o.has_addr = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_gen_pkg::*;
(
    input  ea_dec_t             dec_i,
    input  logic [7:0]          ext_hi_i,
    input  logic [7:0]          ext_lo_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic                is_write_i,
    output ea_calc_t            calc_o
);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] disp8_ext;
    logic [ADDR_W-1:0] disp16_ext;
    logic [ADDR_W-1:0] down_val;
    logic [ADDR_W-1:0] up_val;

    assign step       = size_step(dec_i.word);
    assign disp8_ext  = ADDR_W'($signed(ext_hi_i));
    assign disp16_ext = ADDR_W'($signed({ext_hi_i, ext_lo_i}));
    assign down_val   = base_i - step;
    assign up_val     = base_i + step;

    always_comb begin
        calc_o = '0;
        case (dec_i.mode)
            MODE_PREDEC: begin
                calc_o.addr   = down_val;
                calc_o.wb_en  = 1'b1;
                calc_o.wb_val = down_val;
            end
            MODE_POSTINC: begin
                calc_o.addr   = base_i;
                calc_o.wb_en  = !is_write_i;
                calc_o.wb_val = is_write_i ? '0 : up_val;
            end
            MODE_IND:    calc_o.addr = base_i;
            MODE_DISP8:  calc_o.addr = base_i + disp8_ext;
            MODE_DISP16: calc_o.addr = base_i + disp16_ext;
            MODE_ABS:    calc_o.addr = ADDR_W'({ext_hi_i, ext_lo_i});
            default: ;
        endcase
    end

endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
    import ea_gen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PREFIX_W-1:0]  prefix_i,
    input  logic [7:0]           ext_hi_i,
    input  logic [7:0]           ext_lo_i,
    input  logic [ADDR_W-1:0]    base_i,
    input  logic                 is_write_i,
    output logic [3:0]           mode_o,
    output logic                 word_o,
    output logic [LEN_W-1:0]     len_o,
    output logic [REG_W-1:0]     reg_o,
    output logic                 illegal_o,
    output logic                 addr_valid_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic                 wb_en_o,
    output logic [ADDR_W-1:0]    wb_val_o
);

    ea_dec_t  dec_d,  dec_q;
    ea_calc_t calc_d, calc_q;

    ea_prefix_decode u_decode (
        .prefix_i (prefix_i),
        .dec_o    (dec_d)
    );

    ea_addr_calc u_calc (
        .dec_i      (dec_d),
        .ext_hi_i   (ext_hi_i),
        .ext_lo_i   (ext_lo_i),
        .base_i     (base_i),
        .is_write_i (is_write_i),
        .calc_o     (calc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q  <= '0;
            calc_q <= '0;
        end else begin
            dec_q  <= dec_d;
            calc_q <= calc_d;
        end
    end

    assign mode_o       = dec_q.mode;
    assign word_o       = dec_q.word;
    assign len_o        = dec_q.len;
    assign reg_o        = dec_q.reg_idx;
    assign illegal_o    = dec_q.illegal;
    assign addr_valid_o = dec_q.has_addr;
    assign addr_o       = calc_q.addr;
    assign wb_en_o      = calc_q.wb_en;
    assign wb_val_o     = calc_q.wb_val;

    AST_WB_ONLY_AUTOMOD: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> (mode_o == MODE_PREDEC || mode_o == MODE_POSTINC)); // R6

    AST_PREDEC_ADDR_EQ_WB: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_PREDEC && !illegal_o) |-> (wb_en_o && addr_o == wb_val_o)); // R6

    AST_POSTINC_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (prefix_i[7:4] == 4'hC && is_write_i) |=> !wb_en_o); // R7

    AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_POSTINC && wb_en_o) |-> (wb_val_o == addr_o + size_step(word_o))); // R7

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!wb_en_o && len_o == '0 && !addr_valid_o && addr_o == '0)); // R10

    AST_WB_VAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        !wb_en_o |-> (wb_val_o == '0)); // R11

    AST_LATENCY_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (prefix_i == 8'h00) |=> illegal_o); // R2

endmodule

// File: tb/tb_ea_addr_gen.sv
module tb_ea_addr_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  prefix_i, ext_hi_i, ext_lo_i;
    logic [15:0] base_i;
    logic        is_write_i;
    logic [3:0]  mode_o;
    logic        word_o;
    logic [1:0]  len_o;
    logic [2:0]  reg_o;
    logic        illegal_o, addr_valid_o, wb_en_o;
    logic [15:0] addr_o, wb_val_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_addr_gen dut (
        .clk(clk), .rst(rst), .prefix_i(prefix_i), .ext_hi_i(ext_hi_i),
        .ext_lo_i(ext_lo_i), .base_i(base_i), .is_write_i(is_write_i),
        .mode_o(mode_o), .word_o(word_o), .len_o(len_o), .reg_o(reg_o),
        .illegal_o(illegal_o), .addr_valid_o(addr_valid_o), .addr_o(addr_o),
        .wb_en_o(wb_en_o), .wb_val_o(wb_val_o)
    );

    // expected values for the inputs applied in the previous cycle
    typedef struct {
        int mode; int word; int len; int rg; int ill; int hasa;
        int addr; int wben; int wbval;
    } exp_t;

    exp_t pend_q[$];

    function automatic exp_t model(int p, int hi, int lo, int b, int wr);
        exp_t e;
        int nib, sz, d8, d16;
        e = '{mode:15, word:0, len:0, rg:0, ill:1, hasa:0, addr:0, wben:0, wbval:0};
        nib = p / 16;
        if (nib >= 10) begin
            e.mode = nib - 10;
            e.word = (p / 8) % 2;
            e.rg   = p % 8;
            e.ill  = 0;
            e.len  = (nib == 14) ? 2 : (nib == 15) ? 3 : 1;
            sz     = e.word ? 2 : 1;
            d8     = (hi >= 128) ? hi - 256 : hi;
            d16    = hi * 256 + lo;
            if (d16 >= 32768) d16 = d16 - 65536;
            e.hasa = (nib != 10);
            if (nib == 11) begin e.addr = (b - sz + 65536) % 65536; e.wben = 1; e.wbval = e.addr; end
            if (nib == 12) begin e.addr = b; if (!wr) begin e.wben = 1; e.wbval = (b + sz) % 65536; end end
            if (nib == 13) e.addr = b;
            if (nib == 14) e.addr = (b + d8 + 65536) % 65536;
            if (nib == 15) e.addr = (b + d16 + 65536) % 65536;
        end else if (p == 4) begin
            e.mode = 6; e.len = 2; e.ill = 0;
        end else if (p == 12) begin
            e.mode = 7; e.len = 3; e.word = 1; e.ill = 0;
        end else if (p == 21 || p == 29) begin
            e.mode = 8; e.len = 3; e.word = (p == 29); e.ill = 0; e.hasa = 1;
            e.addr = hi * 256 + lo;
        end
        return e;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(exp_t e);
        string tm, ta, tw;
        tm = (e.ill != 0) ? "R2+R10" : (e.mode >= 6) ? "R2+R5" : "R2+R3";
        ta = (e.mode == 1) ? "R6" : (e.mode == 2) ? "R7" : (e.mode == 8) ? "R9" :
             (e.mode >= 3 && e.mode <= 5) ? "R8" : (e.ill != 0) ? "R10" : "R9";
        tw = (e.mode == 1) ? "R6" : (e.mode == 2) ? "R7" : "R11";
        chk(tm, "mode", int'(mode_o), e.mode);
        chk(tm, "word", int'(word_o), e.word);
        chk(tm, "reg", int'(reg_o), e.rg);
        chk(tm, "illegal", int'(illegal_o), e.ill);
        chk("R4", "len", int'(len_o), e.len);
        chk("R9", "addr_valid", int'(addr_valid_o), e.hasa);
        chk(ta, "addr", int'(addr_o), e.addr);
        chk(tw, "wb_en", int'(wb_en_o), e.wben);
        chk(tw, "wb_val", int'(wb_val_o), e.wbval);
    endtask

    // one cycle: check what was applied before, then apply new inputs
    task automatic step(int p, int hi, int lo, int b, int wr);
        @(negedge clk);
        if (pend_q.size() > 0) compare(pend_q.pop_front());
        prefix_i   = 8'(p);
        ext_hi_i   = 8'(hi);
        ext_lo_i   = 8'(lo);
        base_i     = 16'(b);
        is_write_i = wr[0];
        pend_q.push_back(model(p, hi, lo, b, wr));
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R2 actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        prefix_i = 8'hB9; ext_hi_i = 8'h55; ext_lo_i = 8'hAA;
        base_i = 16'h4321; is_write_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs all zero under reset
        chk("R1", "mode", int'(mode_o), 0);
        chk("R1", "len", int'(len_o), 0);
        chk("R1", "addr", int'(addr_o), 0);
        chk("R1", "wb_en", int'(wb_en_o), 0);
        chk("R1", "wb_val", int'(wb_val_o), 0);
        chk("R1", "illegal", int'(illegal_o), 0);
        rst = 1'b0;

        // auto-modify wrap corners, both directions
        for (int w = 0; w < 2; w++) begin
            step(8'hB0, 0, 0, 16'h0000, w);  // R6 byte predec wraps to FFFF
            step(8'hB8, 0, 0, 16'h0000, w);  // R6 word predec wraps to FFFE
            step(8'hBB, 0, 0, 16'h0001, w);  // R6 word predec wraps to FFFF
            step(8'hC3, 0, 0, 16'hFFFF, w);  // R7 byte postinc wraps to 0
            step(8'hCF, 0, 0, 16'hFFFF, w);  // R7 word postinc wraps to 1
            step(8'hCA, 0, 0, 16'hFFFE, w);  // R7 word postinc wraps to 0
        end
        step(8'hE1, 8'h7F, 0, 16'h0005, 0);      // R8 positive disp8
        step(8'hE9, 8'h80, 0, 16'h0005, 0);      // R8 negative disp8 wraps
        step(8'hF2, 8'hFF, 8'hFF, 16'h0001, 1);  // R8 disp16 -1 wraps to 0
        step(8'hFA, 8'h7F, 8'hFF, 16'h8001, 0);  // R8 disp16 carry out
        step(8'h1D, 8'hFF, 8'hFE, 16'h1234, 1);  // R9 absolute word
        step(8'h15, 8'h00, 8'h10, 16'h1234, 0);  // R9 absolute byte
        step(8'h04, 8'h12, 8'h34, 16'h1234, 0);  // R5 byte immediate
        step(8'h0C, 8'h12, 8'h34, 16'h1234, 1);  // R5 word immediate
        step(8'h00, 8'h12, 8'h34, 16'h1234, 0);  // R10 illegal
        step(8'h9F, 8'h12, 8'h34, 16'hFFFF, 0);  // R10 illegal below family

        // full prefix sweep, read then write
        for (int w = 0; w < 2; w++)
            for (int p = 0; p < 256; p++)
                step(p, 8'h80, 8'h01, 16'h1234, w);

        // random patterns
        for (int i = 0; i < 3000; i++)
            step(int'($urandom_range(255)), int'($urandom_range(255)),
                 int'($urandom_range(255)), int'($urandom_range(65535)),
                 int'($urandom_range(1)));

        @(negedge clk);
        if (pend_q.size() > 0) compare(pend_q.pop_front());
        done = 1;
        finish_run();
    end

endmodule